// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive side of an Ethernet MAC. When a frame begins, the parser presents its 48-bit destination address with a one-cycle strobe. One cycle later the filter reports whether the frame should be kept. It also reports whether the frame is unicast, multicast or broadcast. The verdict and the class then stay steady for the whole frame, until the parser signals the end of the frame.

A unicast destination is compared against one primary station address and a set of supplementary addresses. A multicast destination is folded into a 6-bit index, and that index selects one bit of a 64-entry hash table. Software loads the table through a single-bit write port. The all-ones broadcast address is always kept. Promiscuous mode keeps every frame, but the class is still reported.

Top module: `dest_addr_filter`

## Requirements
- R1: With promiscuous mode off, a unicast destination (address bit 40 clear) is accepted when it equals the primary address or any of the four supplementary addresses; its class has bit 4 set.
- R2: With promiscuous mode off, a unicast destination that matches no configured address is discarded (accept low), and class bit 4 is still set.
- R3: The hash index bit k (k = 0..5) is the XOR of address bits 8k+7 down to 8k, so index bit 5 folds bits 47:40 and index bit 0 folds bits 7:0.
- R4: A destination with bit 40 set that is not all ones is classed as multicast (class bit 2). With promiscuous mode off, it is accepted exactly when the hash table entry at its index holds 1.
- R5: The all-ones destination is always accepted, and its class is bit 3 only (never multicast).
- R6: With promiscuous mode on, every frame is accepted, and the class bits are the same as with promiscuous mode off.
- R7: `frame_sop` pulses for exactly one cycle, in the cycle after `addr_valid`. The accept and class outputs take their new values in that same cycle. Class bits 1 and 0 are always 0, and at most one class bit is set.
- R8: Accept and class hold their values until the cycle after a `frame_end` pulse, when both clear to 0. A strobe in the same cycle as `frame_end` loads the new result instead.
- R9: A hash table write takes effect for strobes from the next cycle on. A write in the same cycle as a strobe does not affect that strobe's lookup.
- R10: After reset, `frame_sop`, accept and class are 0, and every hash table entry is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_valid | input | 1 | Destination address strobe at frame start |
| dest_addr | input | 48 | Destination address of the frame |
| frame_end | input | 1 | Pulse marking end of frame; clears held results |
| promisc_en | input | 1 | Promiscuous mode enable |
| station_addr | input | 48 | Primary station address |
| extra_addr | input | 192 | Four supplementary addresses, entry i at bits 48i+47:48i |
| hash_we | input | 1 | Hash table write enable |
| hash_waddr | input | 6 | Hash table entry to write |
| hash_wdata | input | 1 | Value written to the entry |
| frame_sop | output | 1 | One-cycle pulse when a new result is presented |
| accept | output | 1 | 1 keeps the frame, 0 discards it |
| frame_class | output | 5 | Bit 4 unicast, bit 3 broadcast, bit 2 multicast, bits 1:0 zero |

## Verification
Directed addresses come first. These are the primary address, each supplementary address in turn, near-miss unicasts that differ by one bit, broadcast, and multicasts whose hash entry is set or clear. They separate the address-compare path from the hash path, and a wrong supplementary slot or a wrong octet fold shows up as a flipped accept. Promiscuous mode is then toggled against the same addresses, which shows that it overrides only the accept verdict. A seeded random mix of all address kinds, hash rewrites and promiscuous settings follows. It covers hash indices and match slots that the directed cases miss. The frame-end timing, and a write made in the same cycle as a strobe, are checked directly.

// File: rtl/addr_filter_pkg.sv
package addr_filter_pkg;
   localparam int CLS_W       = 5;
   localparam int CLS_UNICAST = 4;
   localparam int CLS_BCAST   = 3;
   localparam int CLS_MCAST   = 2;

   typedef enum logic [1:0] {
      KIND_UNICAST = 2'd0,
      KIND_MCAST   = 2'd1,
      KIND_BCAST   = 2'd2
   } addr_kind_e;

   typedef struct packed {
      logic             keep;
      logic [CLS_W-1:0] cls;
   } verdict_t;

   function automatic logic [CLS_W-1:0] kind_to_cls(addr_kind_e k);
      logic [CLS_W-1:0] c;
      c = '0;
      case (k)
         KIND_UNICAST: c[CLS_UNICAST] = 1'b1;
         KIND_MCAST:   c[CLS_MCAST]   = 1'b1;
         KIND_BCAST:   c[CLS_BCAST]   = 1'b1;
         default:      c = '0;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/addr_match_bank.sv
module addr_match_bank #(
   parameter int ADDR_W    = 48,
   parameter int NUM_EXTRA = 4
) (
   input  logic [ADDR_W-1:0]                     dest,
   input  logic [ADDR_W-1:0]                     primary,
   input  logic [(NUM_EXTRA>0?NUM_EXTRA:1)*ADDR_W-1:0] extra,
   output logic                                  hit
);
   localparam int SLOTS = (NUM_EXTRA > 0) ? NUM_EXTRA : 1;

   logic primary_hit;
   logic [SLOTS-1:0] slot_hit;

   assign primary_hit = (dest == primary);

   generate
      if (NUM_EXTRA > 0) begin : g_extra
         for (genvar i = 0; i < NUM_EXTRA; i++) begin : g_slot
            assign slot_hit[i] = (dest == extra[i*ADDR_W +: ADDR_W]);
         end
      end else begin : g_none
         assign slot_hit = '0;
      end
   endgenerate

   assign hit = primary_hit | (|slot_hit);
endmodule

// File: rtl/hash_index_gen.sv
module hash_index_gen #(
   parameter int ADDR_W = 48,
   localparam int IDX_W = ADDR_W / 8
) (
   input  logic [ADDR_W-1:0] dest,
   output logic [IDX_W-1:0]  idx
);
   generate
      for (genvar k = 0; k < IDX_W; k++) begin : g_fold
         assign idx[k] = ^dest[8*k +: 8];
      end
   endgenerate
endmodule

// File: rtl/mcast_hash_table.sv
module mcast_hash_table #(
   parameter int IDX_W = 6,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] waddr,
   input  logic             wdata,
   input  logic [IDX_W-1:0] raddr,
   output logic             rdata
);
   logic [DEPTH-1:0] bits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else if (we) begin
         bits_q[waddr] <= wdata;
      end
   end

   assign rdata = bits_q[raddr];
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
   import addr_filter_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int NUM_EXTRA = 4,
   localparam int IDX_W    = ADDR_W / 8,
   localparam int MC_BIT   = ADDR_W - 8,
   localparam int EXTRA_W  = (NUM_EXTRA > 0 ? NUM_EXTRA : 1) * ADDR_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               addr_valid,
   input  logic [ADDR_W-1:0]  dest_addr,
   input  logic               frame_end,
   input  logic               promisc_en,
   input  logic [ADDR_W-1:0]  station_addr,
   input  logic [EXTRA_W-1:0] extra_addr,
   input  logic               hash_we,
   input  logic [IDX_W-1:0]   hash_waddr,
   input  logic               hash_wdata,
   output logic               frame_sop,
   output logic               accept,
   output logic [CLS_W-1:0]   frame_class
);
   generate
      if (ADDR_W % 8 != 0 || ADDR_W < 16) begin : g_bad_width
         $error("ADDR_W must be a multiple of 8 and at least 16");
      end
      if (NUM_EXTRA < 0 || NUM_EXTRA > 16) begin : g_bad_extra
         $error("NUM_EXTRA must lie in 0..16");
      end
   endgenerate

   logic             uc_hit;
   logic [IDX_W-1:0] hidx;
   logic             hbit;
   addr_kind_e       kind;
   verdict_t         dec, held_q;
   logic             sop_q;

   addr_match_bank #(.ADDR_W(ADDR_W), .NUM_EXTRA(NUM_EXTRA)) u_match (
      .dest(dest_addr), .primary(station_addr), .extra(extra_addr), .hit(uc_hit)
   );

   hash_index_gen #(.ADDR_W(ADDR_W)) u_hidx (
      .dest(dest_addr), .idx(hidx)
   );

   mcast_hash_table #(.IDX_W(IDX_W)) u_table (
      .clk(clk), .rst_n(rst_n), .we(hash_we), .waddr(hash_waddr),
      .wdata(hash_wdata), .raddr(hidx), .rdata(hbit)
   );

   always_comb begin
      if (&dest_addr)              kind = KIND_BCAST;
      else if (dest_addr[MC_BIT])  kind = KIND_MCAST;
      else                         kind = KIND_UNICAST;

      dec.cls = kind_to_cls(kind);
      case (kind)
         KIND_BCAST:   dec.keep = 1'b1;
         KIND_MCAST:   dec.keep = promisc_en | hbit;
         default:      dec.keep = promisc_en | uc_hit;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sop_q  <= 1'b0;
         held_q <= '0;
      end else if (addr_valid) begin
         sop_q  <= 1'b1;
         held_q <= dec;
      end else begin
         sop_q <= 1'b0;
         if (frame_end) held_q <= '0;
      end
   end

   assign frame_sop   = sop_q;
   assign accept      = held_q.keep;
   assign frame_class = held_q.cls;
endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk #(
   parameter int ADDR_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              addr_valid,
   input logic [ADDR_W-1:0] dest_addr,
   input logic              frame_end,
   input logic              promisc_en,
   input logic              frame_sop,
   input logic              accept,
   input logic [4:0]        frame_class
);
   assert_promisc_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && promisc_en |=> accept);

   assert_bcast_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
      addr_valid && (&dest_addr) |=> accept && frame_class == 5'b01000);

   assert_sop_follows_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_sop |-> $past(addr_valid));

   assert_class_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(frame_class) && frame_class[1:0] == 2'b00);

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !addr_valid && !frame_end |=> $stable({accept, frame_class}));

   assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end && !addr_valid |=> !accept && frame_class == 5'b00000);
endmodule

bind dest_addr_filter addr_filter_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .dest_addr(dest_addr),
   .frame_end(frame_end), .promisc_en(promisc_en), .frame_sop(frame_sop),
   .accept(accept), .frame_class(frame_class)
);

// File: tb/test_dest_addr_filter.sv
`timescale 1ns/1ps
module test_dest_addr_filter;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         addr_valid = 1'b0;
   logic [47:0]  dest_addr = '0;
   logic         frame_end = 1'b0;
   logic         promisc_en = 1'b0;
   logic [47:0]  station_addr;
   logic [191:0] extra_addr;
   logic         hash_we = 1'b0;
   logic [5:0]   hash_waddr = '0;
   logic         hash_wdata = 1'b0;
   logic         frame_sop, accept;
   logic [4:0]   frame_class;

   logic [63:0]  tb_hash = '0;
   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dest_addr_filter i_dest_addr_filter (
      .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .dest_addr(dest_addr),
      .frame_end(frame_end), .promisc_en(promisc_en), .station_addr(station_addr),
      .extra_addr(extra_addr), .hash_we(hash_we), .hash_waddr(hash_waddr),
      .hash_wdata(hash_wdata), .frame_sop(frame_sop), .accept(accept),
      .frame_class(frame_class)
   );

   function automatic logic [5:0] ref_idx(logic [47:0] a);
      logic [5:0] r;
      for (int k = 0; k < 6; k++) r[k] = ^a[8*k +: 8];
      return r;
   endfunction

   function automatic logic [5:0] ref_verdict(logic [47:0] a, logic p);
      logic m;
      m = (a == station_addr);
      for (int i = 0; i < 4; i++) if (a == extra_addr[48*i +: 48]) m = 1'b1;
      if (&a)       return {1'b1, 5'b01000};
      else if (a[40]) return {p | tb_hash[ref_idx(a)], 5'b00100};
      else          return {p | m, 5'b10000};
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hwrite(logic [5:0] a, logic d);
      @(negedge clk);
      hash_we = 1'b1; hash_waddr = a; hash_wdata = d;
      @(negedge clk);
      hash_we = 1'b0;
      tb_hash[a] = d;
   endtask

   task automatic frame(string req, logic [47:0] a, logic p);
      logic [5:0] e;
      e = ref_verdict(a, p);
      @(negedge clk);
      dest_addr = a; promisc_en = p; addr_valid = 1'b1;
      @(negedge clk);
      addr_valid = 1'b0;
      check({req, " sop R7"}, frame_sop, 1);
      check(req, {accept, frame_class}, e);
      @(negedge clk);
      check({req, " hold R8"}, {frame_sop, accept, frame_class}, {1'b0, e});
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
      check({req, " clear R8"}, {accept, frame_class}, 0);
   endtask

   initial begin
      #800000;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [47:0] a;
      logic [5:0] e;
      void'($urandom(32'd1234));
      station_addr = 48'h02_11_22_33_44_56;
      extra_addr = {48'h0A_BB_CC_DD_EE_04, 48'h0A_BB_CC_DD_EE_03,
                    48'h0A_BB_CC_DD_EE_02, 48'h0A_BB_CC_DD_EE_01};
      repeat (3) @(negedge clk);
      check("R10 reset outputs", {frame_sop, accept, frame_class}, 0);
      rst_n = 1'b1;

      // R10: table empty after reset, multicast discarded
      frame("R10 table clear", 48'h01_00_5E_00_00_01, 1'b0);

      // R1: primary and every supplementary slot
      frame("R1 primary", station_addr, 1'b0);
      for (int i = 0; i < 4; i++) frame("R1 supplementary", extra_addr[48*i +: 48], 1'b0);
      // R2: near misses
      frame("R2 miss", station_addr ^ 48'h1, 1'b0);
      frame("R2 miss high", station_addr ^ 48'h02_00_00_00_00_00, 1'b0);

      // R5 broadcast
      frame("R5 broadcast", '1, 1'b0);

      // R3/R4: set entry for index computed per octet
      a = 48'h01_00_00_00_00_00;            // idx: octet5 ^=1 -> bit5=1
      check("R3 index fold", ref_idx(a), 6'b100000);
      hwrite(6'b100000, 1'b1);
      frame("R4 mcast hit R3", a, 1'b0);
      frame("R4 mcast miss R3", 48'h01_00_00_00_00_01, 1'b0);
      a = 48'h03_00_00_00_00_01;            // octet5 xor 0 -> idx 000001
      hwrite(6'b000001, 1'b1);
      frame("R4 mcast low octet R3", a, 1'b0);

      // R6 promiscuous
      frame("R6 promisc unicast", 48'h00_DE_AD_BE_EF_00, 1'b1);
      frame("R6 promisc mcast", 48'h01_00_00_00_00_03, 1'b1);
      frame("R6 promisc bcast", '1, 1'b1);

      // R9: write in same cycle as strobe uses old entry
      a = 48'h01_00_00_00_00_07;            // idx = 100001 ^ ... compute
      e = ref_verdict(a, 1'b0);
      @(negedge clk);
      dest_addr = a; promisc_en = 1'b0; addr_valid = 1'b1;
      hash_we = 1'b1; hash_waddr = ref_idx(a); hash_wdata = ~tb_hash[ref_idx(a)];
      @(negedge clk);
      addr_valid = 1'b0; hash_we = 1'b0;
      check("R9 same-cycle write", {accept, frame_class}, e);
      tb_hash[ref_idx(a)] = ~tb_hash[ref_idx(a)];
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
      frame("R9 after write", a, 1'b0);

      // R8: strobe with frame_end loads new result
      @(negedge clk);
      dest_addr = '1; addr_valid = 1'b1;
      @(negedge clk);
      addr_valid = 1'b0;
      e = ref_verdict(station_addr, 1'b0);
      dest_addr = station_addr; addr_valid = 1'b1; frame_end = 1'b1;
      @(negedge clk);
      addr_valid = 1'b0; frame_end = 1'b0;
      check("R8 strobe beats end", {frame_sop, accept, frame_class}, {1'b1, e});
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;

      // random mix
      for (int n = 0; n < 300; n++) begin
         int kind;
         if ($urandom_range(0, 3) == 0)
            hwrite(6'($urandom_range(0, 63)), 1'($urandom_range(0, 1)));
         kind = $urandom_range(0, 4);
         case (kind)
            0: a = station_addr;
            1: a = extra_addr[48*$urandom_range(0, 3) +: 48];
            2: a = {$urandom, 16'($urandom)} & ~48'h01_00_00_00_00_00;
            3: a = {$urandom, 16'($urandom)} | 48'h01_00_00_00_00_00;
            default: a = '1;
         endcase
         frame("R1 R2 R4 R5 R6 random", a, 1'($urandom_range(0, 1)));
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule